// File: doc/BRIEF.md
# Signed/Unsigned Fractional 8x8 Multiplier

A two-cycle multiplier for the datapath of a small 8-bit processor. The decoder hands it two operand bytes, a 3-bit operation select and a one-cycle start strobe. Exactly two clock edges later the block presents a 16-bit product as a high byte and a low byte, together with a zero flag and a carry flag, and pulses done for one cycle. The core writes the two bytes into a fixed destination register pair. It writes the two flags into its status word and leaves every other status bit alone.

The operation select chooses among three signedness combinations: both operands unsigned, both signed, and a signed first operand with an unsigned second operand. Each combination has an integer form and a fractional form. The fractional form treats the operands as Q7 values and shifts the full product left by one bit, so the result lines up as a Q15 value. Carry always reports the sign/top bit of the product before that shift. Zero reports whether the delivered 16 bits are all clear.

Top module: `qmul_unit`

## Requirements
- R1: Operation select encoding: bit 2 set selects the fractional form. Bits 1:0 select the signedness: 00 means unsigned x unsigned, 01 means signed x signed, 10 means signed first x unsigned second, and the spare code 11 behaves exactly like 00.
- R2: In the unsigned integer mode the result is the 16-bit unsigned product of the two operand bytes (0xFF x 0xFF gives 0xFE01).
- R3: In the signed integer mode both bytes are two's complement and the result is their 16-bit two's complement product (0x80 x 0x7F gives 0xC080).
- R4: In the mixed integer mode the first byte is two's complement and the second is unsigned (0xFF x 0xFF gives 0xFF01).
- R5: A fractional mode returns the matching integer product shifted left by one bit, truncated to 16 bits, with bit 0 clear (signed 0x80 x 0x80 gives 0x8000).
- R6: Carry equals bit 15 of the product before any fractional shift.
- R7: Zero is 1 exactly when the delivered 16-bit result equals 0x0000.
- R8: A start sampled by a clock edge while idle makes done high for exactly one cycle, starting just after the second edge from that start. Result and flags are valid in that same cycle.
- R9: A start sampled while an operation is in flight is ignored. It produces no done pulse and does not alter the result.
- R10: Result and flags change only on the edge that raises done and hold their values until the next done.
- R11: While reset is asserted, the result, both flags and done are 0. Reset aborts any operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one operation |
| op_i | input | 3 | Operation select (R1 encoding) |
| opa_i | input | 8 | First operand byte |
| opb_i | input | 8 | Second operand byte |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| zero_o | output | 1 | Zero flag of the last result |
| carry_o | output | 1 | Carry flag of the last result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block at its default operand width of 8 with PIPE_SPLIT=1. In that variant the raw product is registered in the first cycle, and shift and flag generation happen in the second. At that width every mode can be checked against an arithmetic reference computed in the bench. The check covers the extremes 0x00, 0x7F, 0x80 and 0xFF in every pairing under all eight select codes, including the spare codes. It also covers the signed fractional wrap of 0x80 x 0x80 and a long random sweep. The 2-edge latency is checked at the ports, and so are the ignored start while busy and reset during an operation.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

   // signedness field of the operation select
   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_RSV = 2'b11
   } sgn_mode_e;

   typedef struct packed {
      logic frac;
      logic a_signed;
      logic b_signed;
   } mode_t;

   function automatic mode_t decode_op(input logic [2:0] op);
      mode_t m;
      m.frac = op[2];
      unique case (sgn_mode_e'(op[1:0]))
         SGN_SS:  begin m.a_signed = 1'b1; m.b_signed = 1'b1; end
         SGN_SU:  begin m.a_signed = 1'b1; m.b_signed = 1'b0; end
         default: begin m.a_signed = 1'b0; m.b_signed = 1'b0; end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/qmul_ctrl.sv
module qmul_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic accept_o,
   output logic fin_o,
   output logic done_o
);

   logic busy_q;
   logic done_q;

   assign accept_o = start_i & ~busy_q;
   assign fin_o    = busy_q;
   assign done_o   = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         busy_q <= accept_o;
         done_q <= busy_q;
      end
   end

   // R8
   accept_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |-> ##2 done_q);

   // R8
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R9
   no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> !busy_q);

endmodule

// File: rtl/qmul_opnd.sv
module qmul_opnd #(
   parameter int W = 8,
   localparam int P = 2 * W
) (
   input  logic [W-1:0] val_i,
   input  logic         sgn_i,
   output logic [P-1:0] ext_o
);

   assign ext_o[W-1:0] = val_i;

   for (genvar i = W; i < P; i++) begin : g_ext
      assign ext_o[i] = sgn_i & val_i[W-1];
   end

endmodule

// File: rtl/qmul_core.sv
module qmul_core #(
   parameter int W          = 8,
   parameter int PIPE_SPLIT = 1,
   localparam int P = 2 * W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         fin_i,
   input  logic         frac_i,
   input  logic [P-1:0] a_ext_i,
   input  logic [P-1:0] b_ext_i,
   output logic [P-1:0] res_o,
   output logic         carry_o,
   output logic         zero_o
);

   logic         frac_s1;
   logic [P-1:0] raw_w;
   logic [P-1:0] shaped_w;
   logic [P-1:0] res_q;
   logic         carry_q;
   logic         zero_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frac_s1 <= 1'b0;
      end else if (load_i) begin
         frac_s1 <= frac_i;
      end
   end

   if (PIPE_SPLIT == 1) begin : g_mul_early
      // multiply in the first cycle, shape in the second
      logic [P-1:0] raw_s1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            raw_s1 <= '0;
         end else if (load_i) begin
            raw_s1 <= a_ext_i * b_ext_i;
         end
      end
      assign raw_w = raw_s1;
   end else begin : g_mul_late
      // hold operands in the first cycle, multiply and shape in the second
      logic [P-1:0] a_s1;
      logic [P-1:0] b_s1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            a_s1 <= '0;
            b_s1 <= '0;
         end else if (load_i) begin
            a_s1 <= a_ext_i;
            b_s1 <= b_ext_i;
         end
      end
      assign raw_w = a_s1 * b_s1;
   end

   assign shaped_w = frac_s1 ? {raw_w[P-2:0], 1'b0} : raw_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q   <= '0;
         carry_q <= 1'b0;
         zero_q  <= 1'b0;
      end else if (fin_i) begin
         res_q   <= shaped_w;
         carry_q <= raw_w[P-1];
         zero_q  <= (shaped_w == '0);
      end
   end

   assign res_o   = res_q;
   assign carry_o = carry_q;
   assign zero_o  = zero_q;

   // R5
   frac_lsb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin_i && frac_s1) |=> (res_q[0] == 1'b0));

   // R6
   int_carry_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin_i && !frac_s1) |=> (carry_q == res_q[P-1]));

endmodule

// File: rtl/qmul_unit.sv
module qmul_unit #(
   parameter int W          = 8,
   parameter int PIPE_SPLIT = 1,
   localparam int P = 2 * W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [2:0]   op_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic [W-1:0] prod_hi_o,
   output logic [W-1:0] prod_lo_o,
   output logic         zero_o,
   output logic         carry_o,
   output logic         done_o
);

   import qmul_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("qmul_unit: W must be at least 2");
   end
   if (PIPE_SPLIT != 0 && PIPE_SPLIT != 1) begin : g_bad_split
      $error("qmul_unit: PIPE_SPLIT must be 0 or 1");
   end

   mode_t        mode_w;
   logic         accept_w;
   logic         fin_w;
   logic [P-1:0] a_ext_w;
   logic [P-1:0] b_ext_w;
   logic [P-1:0] res_w;

   assign mode_w = decode_op(op_i);

   qmul_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .accept_o (accept_w),
      .fin_o    (fin_w),
      .done_o   (done_o)
   );

   qmul_opnd #(.W(W)) u_ext_a (
      .val_i (opa_i),
      .sgn_i (mode_w.a_signed),
      .ext_o (a_ext_w)
   );

   qmul_opnd #(.W(W)) u_ext_b (
      .val_i (opb_i),
      .sgn_i (mode_w.b_signed),
      .ext_o (b_ext_w)
   );

   qmul_core #(.W(W), .PIPE_SPLIT(PIPE_SPLIT)) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept_w),
      .fin_i   (fin_w),
      .frac_i  (mode_w.frac),
      .a_ext_i (a_ext_w),
      .b_ext_i (b_ext_w),
      .res_o   (res_w),
      .carry_o (carry_o),
      .zero_o  (zero_o)
   );

   assign prod_hi_o = res_w[P-1:W];
   assign prod_lo_o = res_w[W-1:0];

   // R10
   hold_between_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable({prod_hi_o, prod_lo_o, zero_o, carry_o}));

   // R7
   zero_matches_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (zero_o == ({prod_hi_o, prod_lo_o} == '0)));

endmodule

// File: tb/qmul_unit_tb.sv
module qmul_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam int N_RAND     = 3000;
   localparam int N_VEC      = 13;

   // {op[2:0], a[7:0], b[7:0], result[15:0], carry, zero}
   localparam logic [36:0] VEC [N_VEC] = '{
      {3'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},
      {3'd1, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},
      {3'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b1, 1'b0},
      {3'd5, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
      {3'd4, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
      {3'd6, 8'h80, 8'hFF, 16'h0100, 1'b1, 1'b0},
      {3'd0, 8'h00, 8'h7F, 16'h0000, 1'b0, 1'b1},
      {3'd5, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0},
      {3'd1, 8'h80, 8'h7F, 16'hC080, 1'b1, 1'b0},
      {3'd3, 8'h10, 8'h10, 16'h0100, 1'b0, 1'b0},
      {3'd7, 8'h80, 8'h02, 16'h0200, 1'b0, 1'b0},
      {3'd4, 8'h80, 8'h00, 16'h0000, 1'b0, 1'b1},
      {3'd5, 8'hFF, 8'h80, 16'h0100, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] op = '0;
   logic [7:0] opa = '0;
   logic [7:0] opb = '0;
   logic [7:0] hi;
   logic [7:0] lo;
   logic       zf;
   logic       cf;
   logic       done;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qmul_unit dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .op_i      (op),
      .opa_i     (opa),
      .opb_i     (opb),
      .prod_hi_o (hi),
      .prod_lo_o (lo),
      .zero_o    (zf),
      .carry_o   (cf),
      .done_o    (done)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // bench reference: {carry, zero, result}
   function automatic logic [17:0] ref_calc(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
      int ia, ib, p;
      logic [15:0] raw, res;
      ia = (o[1:0] == 2'b01 || o[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
      ib = (o[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
      p   = ia * ib;
      raw = p[15:0];
      res = o[2] ? {raw[14:0], 1'b0} : raw;
      return {raw[15], (res == 16'h0000), res};
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      if (o[1:0] == 2'b11) return "R1";
      if (o[2])            return "R5";
      if (o[1:0] == 2'b01) return "R3";
      if (o[1:0] == 2'b10) return "R4";
      return "R2";
   endfunction

   // start at one negedge, sample two negedges later (after the second edge)
   task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      start = 1'b1; op = o; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_and_compare(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                                  input logic [17:0] exp, input string tag);
      run_op(o, a, b);
      check({tag, " result"}, {16'h0, hi, lo}, {16'h0, exp[15:0]});
      check("R6 carry", {31'h0, cf}, {31'h0, exp[17]});
      check("R7 zero", {31'h0, zf}, {31'h0, exp[16]});
      check("R8 done", {31'h0, done}, 32'h1);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 reset result", {16'h0, hi, lo}, 32'h0);
      check("R11 reset flags", {30'h0, zf, cf}, 32'h0);
      check("R11 reset done", {31'h0, done}, 32'h0);
      rst_n = 1'b1;

      // R8: no done one edge after start
      @(negedge clk);
      start = 1'b1; op = 3'd0; opa = 8'h02; opb = 8'h03;
      @(negedge clk);
      start = 1'b0;
      check("R8 no early done", {31'h0, done}, 32'h0);
      @(negedge clk);
      check("R8 done on second edge", {31'h0, done}, 32'h1);
      check("R2 result", {16'h0, hi, lo}, 32'h0006);
      @(negedge clk);
      check("R8 done one cycle", {31'h0, done}, 32'h0);
      check("R10 hold", {16'h0, hi, lo}, 32'h0006);

      // table of directed vectors
      for (int i = 0; i < N_VEC; i++) begin
         run_and_compare(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18],
                         {VEC[i][1], VEC[i][0], VEC[i][17:2]}, tag_of(VEC[i][36:34]));
      end

      // corner values, every select code
      for (int o = 0; o < 8; o++) begin
         for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
               logic [7:0] ca, cb;
               ca = (ia == 0) ? 8'h00 : (ia == 1) ? 8'h7F : (ia == 2) ? 8'h80 : 8'hFF;
               cb = (ib == 0) ? 8'h00 : (ib == 1) ? 8'h7F : (ib == 2) ? 8'h80 : 8'hFF;
               run_and_compare(3'(o), ca, cb, ref_calc(3'(o), ca, cb), tag_of(3'(o)));
            end
         end
      end

      // R9: second start while busy is ignored
      @(negedge clk);
      start = 1'b1; op = 3'd0; opa = 8'h03; opb = 8'h05;
      @(negedge clk);
      op = 3'd0; opa = 8'hFF; opb = 8'hFF;
      @(negedge clk);
      start = 1'b0;
      check("R9 first result kept", {16'h0, hi, lo}, 32'h000F);
      check("R8 done busy case", {31'h0, done}, 32'h1);
      @(negedge clk);
      check("R9 no extra done", {31'h0, done}, 32'h0);
      @(negedge clk);
      check("R9 still no done", {31'h0, done}, 32'h0);
      check("R10 result held", {16'h0, hi, lo}, 32'h000F);

      // R11: reset during an operation
      @(negedge clk);
      start = 1'b1; op = 3'd0; opa = 8'hFF; opb = 8'hFF;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 abort result", {16'h0, hi, lo}, 32'h0);
      check("R11 abort done", {31'h0, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 no late done", {31'h0, done}, 32'h0);

      // random sweep
      for (int k = 0; k < N_RAND; k++) begin
         logic [2:0] ro;
         logic [7:0] ra, rb;
         ro = 3'($urandom_range(0, 7));
         ra = 8'($urandom_range(0, 255));
         rb = 8'($urandom_range(0, 255));
         run_and_compare(ro, ra, rb, ref_calc(ro, ra, rb), tag_of(ro));
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule